// File: doc/BRIEF.md
# SD Card SPI-Mode Command Engine

This block carries out a single SD-card command over SPI, one byte at a time. A single-cycle start strobe samples a 6-bit command index, a 32-bit argument, a count of trailing bytes to collect and a keep-selected flag. The block then pulls chip select low and sends the six-byte command frame through a byte-exchange port to an external serializer. After the frame it keeps sending all-ones filler bytes until the card returns a byte with its top bit clear. That byte is the first response byte. If no such byte arrives within a bounded number of polls, the command ends with a timeout.

When the command finishes, the block raises chip select and clocks one more filler byte. The exception is keep-selected mode after a valid response: chip select then stays low so that a data phase can follow in the same selection. If trailing bytes were requested, they are collected after the response byte into a 32-bit word, oldest byte in the most significant position. The three commonly used response flags are decoded as separate outputs.

The serializer handshake works as follows. The engine pulses `spi_req` for one cycle with `spi_tx` valid. The serializer later pulses `spi_ack` for one cycle with the received byte on `spi_rx`. Only one byte is outstanding at any time.

Top module: `sdspi_cmd_engine`

## Requirements
- R1: The first byte requested after an accepted start is `{2'b01, cmd_idx}`, i.e. 0x40 OR the command index.
- R2: Bytes two to five carry `cmd_arg`, bits 31:24 first and bits 7:0 last.
- R3: The sixth byte is 0x95, except that it is 0x87 when the command index is 8.
- R4: Every byte after the frame and before the closing byte is 0xFF. The first received poll byte with bit 7 equal to 0 appears on `resp` when `done` pulses, with `timeout` low.
- R5: If POLL_LIMIT (default 5000) poll bytes all have bit 7 set, the command ends with `timeout` high and `resp` = 0xFF, and chip select is always released. A valid byte on poll number POLL_LIMIT is still accepted.
- R6: On a normal end, `cs_n` rises and exactly one 0xFF byte is then exchanged with `cs_n` high. `done` pulses after that exchange completes.
- R7: In keep-selected mode with a valid response, no closing byte is sent and `cs_n` stays low after `done`.
- R8: `extra_cnt` (0..4, larger values clamped to 4) bytes following the response are shifted into `extra_data`, which is cleared at start. With 2 bytes a then b, the result is 0x0000_aabb.
- R9: `busy` is high from an accepted start until `done`. A start while busy is ignored and does not change the frame being sent. No byte is requested while idle.
- R10: After reset, `cs_n` = 1 and `busy`, `done`, `timeout` and `spi_req` are all 0.
- R11: `r1_idle`, `r1_illegal` and `r1_crc_err` are bits 0, 2 and 3 of `resp`, forced to 0 when `timeout` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a command (ignored while busy) |
| cmd_idx | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| extra_cnt | input | 3 | Bytes to collect after the response |
| keep_sel | input | 1 | Leave chip select low after a valid response |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| timeout | output | 1 | Last command found no response |
| resp | output | 8 | Response byte (0xFF on timeout) |
| r1_idle | output | 1 | Response flag: card idle |
| r1_illegal | output | 1 | Response flag: illegal command |
| r1_crc_err | output | 1 | Response flag: command CRC error |
| extra_data | output | 32 | Collected trailing bytes, oldest byte most significant |
| cs_n | output | 1 | Card chip select, active low |
| spi_req | output | 1 | Byte exchange request pulse |
| spi_tx | output | 8 | Byte to transmit |
| spi_ack | input | 1 | Byte exchange finished pulse |
| spi_rx | input | 8 | Byte received |

## Verification
The bench focuses on the edges of the poll window:
- A valid byte on exactly the last allowed poll must be accepted. An engine with an off-by-one counter would wrongly report a timeout or send one poll too many.
- A card that never answers must produce exactly POLL_LIMIT polls followed by a released select, including in keep-selected mode, where a faulty engine would leave the card selected.

Poll bytes carry bit 7 set together with varied low bits, which catches an engine that tests the whole byte instead of bit 7 alone. The bench also covers the 0x87 check byte for command 8, the clamping of trailing-byte counts, and a start pulse issued in the middle of a transaction, which would corrupt the frame on an engine that re-latches its inputs.

// File: rtl/sdspi_pkg.sv
package sdspi_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FRAME,
    ST_POLL,
    ST_EXTRA,
    ST_TRAIL
  } sd_state_e;

  localparam logic [7:0] FILL_BYTE = 8'hFF;
  localparam logic [2:0] FRAME_LAST = 3'd5;

  // Byte number pos (0..5) of the command frame.
  function automatic logic [7:0] frame_byte(input logic [5:0] idx,
                                            input logic [31:0] arg,
                                            input logic [2:0] pos,
                                            input logic [7:0] crc_dflt,
                                            input logic [7:0] crc_if8);
    logic [7:0] b;
    case (pos)
      3'd0:    b = {2'b01, idx};
      3'd1:    b = arg[31:24];
      3'd2:    b = arg[23:16];
      3'd3:    b = arg[15:8];
      3'd4:    b = arg[7:0];
      3'd5:    b = (idx == 6'd8) ? crc_if8 : crc_dflt;
      default: b = FILL_BYTE;
    endcase
    return b;
  endfunction

  // A response byte is recognised by a clear top bit.
  function automatic logic resp_valid(input logic [7:0] b);
    return ~b[7];
  endfunction

endpackage

// File: rtl/sdspi_frame_gen.sv
module sdspi_frame_gen
  import sdspi_pkg::*;
#(
  parameter logic [7:0] CRC_DFLT = 8'h95,
  parameter logic [7:0] CRC_IF8  = 8'h87
) (
  input  logic [5:0]  idx,
  input  logic [31:0] arg,
  input  logic [2:0]  pos,
  output logic [7:0]  byte_o
);
  always_comb byte_o = frame_byte(idx, arg, pos, CRC_DFLT, CRC_IF8);
endmodule

// File: rtl/sdspi_poll_ctr.sv
module sdspi_poll_ctr #(
  parameter int LIMIT = 5000,
  localparam int CW   = $clog2(LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  output logic [CW-1:0] cnt,
  output logic          last
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (clr)  cnt <= '0;
    else if (inc)  cnt <= cnt + 1'b1;
  end
  // The poll being counted now would be poll number LIMIT.
  assign last = (cnt == CW'(LIMIT - 1));
endmodule

// File: rtl/sdspi_tail_shift.sv
module sdspi_tail_shift #(
  parameter int NB = 4,
  localparam int W = 8 * NB
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         shift,
  input  logic [7:0]   din,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= '0;
    else if (clr)    q <= '0;
    else if (shift)  q <= {q[W-9:0], din};
  end
endmodule

// File: rtl/sdspi_cmd_engine.sv
module sdspi_cmd_engine
  import sdspi_pkg::*;
#(
  parameter int         POLL_LIMIT = 5000,
  parameter int         EXTRA_MAX  = 4,
  parameter logic [7:0] CRC_DFLT   = 8'h95,
  parameter logic [7:0] CRC_IF8    = 8'h87,
  localparam int        EW         = $clog2(EXTRA_MAX + 1),
  localparam int        CW         = $clog2(POLL_LIMIT + 1),
  localparam int        XW         = 8 * EXTRA_MAX
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [5:0]    cmd_idx,
  input  logic [31:0]   cmd_arg,
  input  logic [EW-1:0] extra_cnt,
  input  logic          keep_sel,
  output logic          busy,
  output logic          done,
  output logic          timeout,
  output logic [7:0]    resp,
  output logic          r1_idle,
  output logic          r1_illegal,
  output logic          r1_crc_err,
  output logic [XW-1:0] extra_data,
  output logic          cs_n,
  output logic          spi_req,
  output logic [7:0]    spi_tx,
  input  logic          spi_ack,
  input  logic [7:0]    spi_rx
);

  sd_state_e     state;
  logic [2:0]    pos;
  logic [5:0]    lat_cmd;
  logic [31:0]   lat_arg;
  logic [EW-1:0] lat_extra, rem;
  logic          lat_keep;
  logic          cs_q, req_q, done_q, tmo_q;
  logic [7:0]    tx_q, resp_q;

  // Named internal events.
  logic          accept, rx_ok, poll_miss, poll_giveup, extra_shift;
  logic [CW-1:0] poll_cnt;
  logic          poll_last;
  logic [5:0]    f_idx;
  logic [31:0]   f_arg;
  logic [2:0]    f_pos;
  logic [7:0]    f_byte;
  logic [EW-1:0] extra_clamped;

  assign accept      = start && (state == ST_IDLE);
  assign rx_ok       = resp_valid(spi_rx);
  assign poll_miss   = (state == ST_POLL) && spi_ack && !rx_ok;
  assign poll_giveup = poll_miss && poll_last;
  assign extra_shift = (state == ST_EXTRA) && spi_ack;
  assign extra_clamped = (extra_cnt > EW'(EXTRA_MAX)) ? EW'(EXTRA_MAX) : extra_cnt;

  // On accept, the first frame byte comes from the ports directly.
  assign f_idx = accept ? cmd_idx : lat_cmd;
  assign f_arg = accept ? cmd_arg : lat_arg;
  assign f_pos = accept ? 3'd0 : pos + 3'd1;

  sdspi_frame_gen #(.CRC_DFLT(CRC_DFLT), .CRC_IF8(CRC_IF8)) u_frame (
    .idx(f_idx), .arg(f_arg), .pos(f_pos), .byte_o(f_byte)
  );

  sdspi_poll_ctr #(.LIMIT(POLL_LIMIT)) u_poll (
    .clk(clk), .rst_n(rst_n), .clr(accept), .inc(poll_miss),
    .cnt(poll_cnt), .last(poll_last)
  );

  sdspi_tail_shift #(.NB(EXTRA_MAX)) u_tail (
    .clk(clk), .rst_n(rst_n), .clr(accept), .shift(extra_shift),
    .din(spi_rx), .q(extra_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      pos       <= '0;
      lat_cmd   <= '0;
      lat_arg   <= '0;
      lat_extra <= '0;
      lat_keep  <= 1'b0;
      rem       <= '0;
      cs_q      <= 1'b1;
      req_q     <= 1'b0;
      tx_q      <= FILL_BYTE;
      done_q    <= 1'b0;
      tmo_q     <= 1'b0;
      resp_q    <= FILL_BYTE;
    end else begin
      req_q  <= 1'b0;
      done_q <= 1'b0;
      unique case (state)
        ST_IDLE: if (accept) begin
          lat_cmd   <= cmd_idx;
          lat_arg   <= cmd_arg;
          lat_extra <= extra_clamped;
          lat_keep  <= keep_sel;
          tmo_q     <= 1'b0;
          pos       <= '0;
          cs_q      <= 1'b0;
          req_q     <= 1'b1;
          tx_q      <= f_byte;
          state     <= ST_FRAME;
        end
        ST_FRAME: if (spi_ack) begin
          req_q <= 1'b1;
          if (pos == FRAME_LAST) begin
            tx_q  <= FILL_BYTE;
            state <= ST_POLL;
          end else begin
            tx_q <= f_byte;
            pos  <= pos + 3'd1;
          end
        end
        ST_POLL: if (spi_ack) begin
          if (rx_ok) begin
            resp_q <= spi_rx;
            if (lat_extra != '0) begin
              rem   <= lat_extra;
              req_q <= 1'b1;
              tx_q  <= FILL_BYTE;
              state <= ST_EXTRA;
            end else if (lat_keep) begin
              done_q <= 1'b1;
              state  <= ST_IDLE;
            end else begin
              cs_q  <= 1'b1;
              req_q <= 1'b1;
              tx_q  <= FILL_BYTE;
              state <= ST_TRAIL;
            end
          end else if (poll_giveup) begin
            resp_q <= FILL_BYTE;
            tmo_q  <= 1'b1;
            cs_q   <= 1'b1;
            req_q  <= 1'b1;
            tx_q   <= FILL_BYTE;
            state  <= ST_TRAIL;
          end else begin
            req_q <= 1'b1;
            tx_q  <= FILL_BYTE;
          end
        end
        ST_EXTRA: if (spi_ack) begin
          rem <= rem - 1'b1;
          if (rem != EW'(1)) begin
            req_q <= 1'b1;
            tx_q  <= FILL_BYTE;
          end else if (lat_keep) begin
            done_q <= 1'b1;
            state  <= ST_IDLE;
          end else begin
            cs_q  <= 1'b1;
            req_q <= 1'b1;
            tx_q  <= FILL_BYTE;
            state <= ST_TRAIL;
          end
        end
        ST_TRAIL: if (spi_ack) begin
          done_q <= 1'b1;
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy       = (state != ST_IDLE);
  assign done       = done_q;
  assign timeout    = tmo_q;
  assign resp       = resp_q;
  assign r1_idle    = resp_q[0] & ~tmo_q;
  assign r1_illegal = resp_q[2] & ~tmo_q;
  assign r1_crc_err = resp_q[3] & ~tmo_q;
  assign cs_n       = cs_q;
  assign spi_req    = req_q;
  assign spi_tx     = tx_q;

endmodule

// File: rtl/sdspi_cmd_engine_chk.sv
module sdspi_cmd_engine_chk #(
  parameter int POLL_LIMIT = 5000,
  parameter int CW         = 13
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [5:0]    cmd_idx,
  input logic          busy,
  input logic          done,
  input logic          timeout,
  input logic          cs_n,
  input logic          spi_req,
  input logic [7:0]    spi_tx,
  input logic [5:0]    lat_cmd,
  input logic [CW-1:0] poll_cnt
);

  // R1
  frame_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (spi_req && spi_tx == {2'b01, $past(cmd_idx)}));

  // R9
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy) |=> $stable(lat_cmd));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !spi_req);

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  // R5
  poll_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (poll_cnt <= CW'(POLL_LIMIT)));

  // R5
  tmo_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && timeout) |-> cs_n);

  // R6
  release_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> (spi_req && spi_tx == 8'hFF));

endmodule

bind sdspi_cmd_engine sdspi_cmd_engine_chk #(.POLL_LIMIT(POLL_LIMIT), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .cmd_idx(cmd_idx),
  .busy(busy), .done(done), .timeout(timeout), .cs_n(cs_n),
  .spi_req(spi_req), .spi_tx(spi_tx), .lat_cmd(lat_cmd), .poll_cnt(poll_cnt)
);

// File: tb/sdspi_cmd_engine_bench.sv
module sdspi_cmd_engine_bench;

  localparam int LIMIT = 5000;
  localparam int WD    = 40000;

  typedef struct packed {
    logic [5:0]  cmd;
    logic [31:0] arg;
    logic [15:0] dly;
    logic [7:0]  rsp;
    logic [2:0]  ext;
    logic        keep;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{6'd0,  32'h0000_0000, 16'd1, 8'h01, 3'd0, 1'b0},
    '{6'd8,  32'h0000_01AA, 16'd0, 8'h01, 3'd4, 1'b0},
    '{6'd17, 32'h1234_5678, 16'd3, 8'h00, 3'd0, 1'b1},
    '{6'd58, 32'h0000_0000, 16'd2, 8'h00, 3'd4, 1'b0},
    '{6'd55, 32'hDEAD_BEEF, 16'd0, 8'h05, 3'd2, 1'b0},
    '{6'd63, 32'hFFFF_FFFF, 16'd7, 8'h08, 3'd1, 1'b1},
    '{6'd41, 32'h4000_0000, 16'd2, 8'h0C, 3'd7, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic start;
  logic [5:0] cmd_idx;
  logic [31:0] cmd_arg;
  logic [2:0] extra_cnt;
  logic keep_sel;
  logic busy, done, timeout, r1_idle, r1_illegal, r1_crc_err, cs_n, spi_req;
  logic [7:0] resp, spi_tx;
  logic [31:0] extra_data;
  logic spi_ack;
  logic [7:0] spi_rx;

  always #4 clk = ~clk;

  sdspi_cmd_engine u_sdspi_cmd_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_idx(cmd_idx), .cmd_arg(cmd_arg),
    .extra_cnt(extra_cnt), .keep_sel(keep_sel), .busy(busy), .done(done),
    .timeout(timeout), .resp(resp), .r1_idle(r1_idle), .r1_illegal(r1_illegal),
    .r1_crc_err(r1_crc_err), .extra_data(extra_data), .cs_n(cs_n),
    .spi_req(spi_req), .spi_tx(spi_tx), .spi_ack(spi_ack), .spi_rx(spi_rx)
  );

  // Card model configuration (written by the stimulus only).
  int         cfg_dly;
  logic [7:0] cfg_rsp;

  function automatic logic [7:0] ex_byte(input int j);
    return 8'h3C + 8'(8'h11 * j);
  endfunction

  function automatic logic [7:0] rx_for(input int i);
    int k;
    if (i < 6) return 8'hFF;
    k = i - 6;
    if (k < cfg_dly) return 8'h80 | 8'(k & 32'h7F);
    if (k == cfg_dly) return cfg_rsp;
    if (k - cfg_dly - 1 < 4) return ex_byte(k - cfg_dly - 1);
    return 8'hFF;
  endfunction

  // Card model and byte log.
  int         m_idx, req_idx, m_wait, n_bytes;
  logic [7:0] tx_log [16];
  logic       cs_log [16];
  logic       fill_bad, last_cs;
  logic [7:0] last_tx;

  always @(posedge clk) begin
    spi_ack <= 1'b0;
    if (!rst_n) begin
      m_idx <= 0; m_wait <= 0; n_bytes <= 0; fill_bad <= 1'b0;
      spi_rx <= 8'hFF; last_cs <= 1'b1; last_tx <= 8'h00;
    end else begin
      if (start && !busy) begin
        m_idx <= 0; n_bytes <= 0; fill_bad <= 1'b0;
      end
      if (spi_req) begin
        if (m_idx < 16) begin
          tx_log[m_idx] <= spi_tx;
          cs_log[m_idx] <= cs_n;
        end
        if (m_idx >= 6 && spi_tx != 8'hFF) fill_bad <= 1'b1;
        last_cs <= cs_n;
        last_tx <= spi_tx;
        req_idx <= m_idx;
        m_idx   <= m_idx + 1;
        n_bytes <= n_bytes + 1;
        m_wait  <= 2;
      end else if (m_wait == 1) begin
        spi_ack <= 1'b1;
        spi_rx  <= rx_for(req_idx);
        m_wait  <= 0;
      end else if (m_wait > 1) begin
        m_wait <= m_wait - 1;
      end
    end
  end

  int total = 0;
  int bad = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_done(output bit ok);
    int cyc = 0;
    while (!done && cyc < WD) begin
      @(negedge clk);
      cyc++;
    end
    ok = done;
    chk(ok, "watchdog", 64'(cyc), 64'(WD));
  endtask

  task automatic launch(input vec_t v);
    @(negedge clk);
    cmd_idx = v.cmd; cmd_arg = v.arg; extra_cnt = v.ext; keep_sel = v.keep;
    cfg_dly = int'(v.dly); cfg_rsp = v.rsp;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic check_vec(input vec_t v, input bit tmo);
    logic [47:0] exp_frame, act_frame;
    logic [31:0] exp_x;
    logic [7:0]  exp_r;
    int          ne, exp_n;
    ne = (v.ext > 3'd4) ? 4 : int'(v.ext);
    exp_frame = {2'b01, v.cmd, v.arg, (v.cmd == 6'd8) ? 8'h87 : 8'h95};
    act_frame = {tx_log[0], tx_log[1], tx_log[2], tx_log[3], tx_log[4], tx_log[5]};
    chk(act_frame[47:40] == exp_frame[47:40], "R1 head byte", 64'(act_frame[47:40]), 64'(exp_frame[47:40]));
    chk(act_frame[39:8] == exp_frame[39:8], "R2 argument bytes", 64'(act_frame[39:8]), 64'(exp_frame[39:8]));
    chk(act_frame[7:0] == exp_frame[7:0], "R3 check byte", 64'(act_frame[7:0]), 64'(exp_frame[7:0]));
    chk(cs_log[0] == 1'b0, "R1 selected during frame", 64'(cs_log[0]), 64'd0);
    chk(!fill_bad, "R4 filler bytes", 64'(fill_bad), 64'd0);
    if (tmo) begin
      exp_n = 6 + LIMIT + 1;
      chk(timeout == 1'b1, "R5 timeout flag", 64'(timeout), 64'd1);
      chk(resp == 8'hFF, "R5 resp on timeout", 64'(resp), 64'hFF);
      chk({r1_idle, r1_illegal, r1_crc_err} == 3'b000, "R11 flags masked", 64'({r1_idle, r1_illegal, r1_crc_err}), 64'd0);
      chk(cs_n == 1'b1 && last_cs == 1'b1, "R5 release on timeout", 64'({cs_n, last_cs}), 64'd3);
    end else begin
      exp_r = v.rsp;
      exp_x = '0;
      for (int j = 0; j < ne; j++) exp_x = {exp_x[23:0], ex_byte(j)};
      exp_n = 6 + int'(v.dly) + 1 + ne + (v.keep ? 0 : 1);
      chk(timeout == 1'b0, "R4 no timeout", 64'(timeout), 64'd0);
      chk(resp == exp_r, "R4 response byte", 64'(resp), 64'(exp_r));
      chk(extra_data == exp_x, "R8 trailing bytes", 64'(extra_data), 64'(exp_x));
      chk({r1_idle, r1_illegal, r1_crc_err} == {exp_r[0], exp_r[2], exp_r[3]}, "R11 flags",
          64'({r1_idle, r1_illegal, r1_crc_err}), 64'({exp_r[0], exp_r[2], exp_r[3]}));
      if (v.keep)
        chk(cs_n == 1'b0 && last_cs == 1'b0, "R7 still selected", 64'({cs_n, last_cs}), 64'd0);
      else
        chk(cs_n == 1'b1 && last_cs == 1'b1 && last_tx == 8'hFF, "R6 closing byte deselected",
            64'({cs_n, last_cs, last_tx}), 64'({2'b11, 8'hFF}));
    end
    chk(n_bytes == exp_n, "R6 byte count", 64'(n_bytes), 64'(exp_n));
    chk(busy == 1'b0, "R9 busy cleared at done", 64'(busy), 64'd0);
  endtask

  initial begin
    bit ok;
    vec_t v;
    rst_n = 1'b0; start = 1'b0; cmd_idx = '0; cmd_arg = '0; extra_cnt = '0; keep_sel = 1'b0;
    cfg_dly = 0; cfg_rsp = 8'h00;
    repeat (4) @(negedge clk);
    // R10 reset state
    chk({cs_n, busy, done, timeout, spi_req} == 5'b10000, "R10 reset outputs",
        64'({cs_n, busy, done, timeout, spi_req}), 64'b10000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      launch(VECS[i]);
      chk(busy == 1'b1, "R9 busy after start", 64'(busy), 64'd1);
      wait_done(ok);
      check_vec(VECS[i], 1'b0);
    end

    // R5 boundary: valid answer on the very last allowed poll.
    v = '{6'd13, 32'h0000_0042, 16'(LIMIT - 1), 8'h04, 3'd0, 1'b0};
    launch(v); wait_done(ok); check_vec(v, 1'b0);

    // R5 card never answers.
    v = '{6'd9, 32'h0, 16'd6000, 8'h00, 3'd0, 1'b0};
    launch(v); wait_done(ok); check_vec(v, 1'b1);

    // R5 and R7: keep-selected does not hold the card after a timeout.
    v = '{6'd2, 32'h0, 16'd6000, 8'h00, 3'd2, 1'b1};
    launch(v); wait_done(ok); check_vec(v, 1'b1);

    // R9 start pulse while busy must be ignored.
    v = '{6'd24, 32'hA5A5_0F0F, 16'd2, 8'h00, 3'd0, 1'b0};
    launch(v);
    repeat (3) @(negedge clk);
    chk(busy == 1'b1, "R9 busy mid command", 64'(busy), 64'd1);
    cmd_idx = 6'd33; cmd_arg = 32'h0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(ok);
    check_vec(v, 1'b0);
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R9 single done pulse", 64'({done, busy}), 64'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule